// File: doc/BRIEF.md
# Dual Write Posting Buffer

This block sits between a processor's write/read request port and a memory controller's burst write port. Processor writes of one 32-bit word are taken into one of two four-word posting buffers and acknowledged in the same cycle. Later memory completion does not hold up the acknowledge. A write whose word address follows the last word held in the filling buffer is appended to it. Each buffer therefore leaves the block as a single burst of consecutive words, with one start address and a word count.

A write that breaks the sequence closes the filling buffer, which then drains, and the write opens the other buffer in the same cycle. A buffer that reaches four words closes at once. Closed buffers drain in the order they were closed. A processor read that targets a word still held in either buffer is held off until that buffer has drained, so memory order is kept. Such a read also closes the buffer if it was still filling. Byte enables travel with every word and reach memory as a per-beat write mask.

Top module: `wpb_top`

## Requirements
- R1: After reset both buffers are empty: `mem_valid` is 0, and a read to any address is granted in the cycle it is requested.
- R2: Up to four writes to consecutive word addresses (each address one more than the previous) are gathered into one burst whose `mem_addr` is the first address, whose `mem_len` is the number of words, and whose beats carry the data in write order.
- R3: A buffer that holds four words closes without any further processor activity and drains as a four-beat burst.
- R4: A write whose address is not one more than the last word of the filling buffer is accepted in the cycle it is requested when the other buffer is empty. The filling buffer drains with its current count, and the new word stays held in the other buffer.
- R5: `cpu_wr_ack` is high in the same cycle as `cpu_wr_req` whenever a buffer can take the word, even while `mem_ready` is low, and never without `cpu_wr_req`.
- R6: When neither buffer can take the word, `cpu_wr_ack` stays low until a buffer has emptied; no word is lost, and at most eight words are ever held.
- R7: A read (`cpu_rd_req`) whose address equals a word held in either buffer is not granted until that buffer has drained; if that buffer was still filling it is closed so that it drains. A read that hits no held word is granted at once.
- R8: The 4-bit byte enable given with each write (bit i enables data bits 8i+7..8i) is presented unchanged on `mem_be` with that word's beat.
- R9: Buffers drain in the order they were closed. `mem_last` is high only on beat number `mem_len`-1 of a burst, and `mem_len` is between 1 and 4.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_len`, `mem_data`, `mem_be` and `mem_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_req | input | 1 | Processor write request |
| cpu_wr_addr | input | AW (30) | Word address of the write |
| cpu_wr_data | input | 32 | Write data |
| cpu_wr_be | input | 4 | Byte enables of the write |
| cpu_wr_ack | output | 1 | Write posted this cycle |
| cpu_rd_req | input | 1 | Processor read request (takes precedence over a write) |
| cpu_rd_addr | input | AW (30) | Word address of the read |
| cpu_rd_grant | output | 1 | Read may proceed to memory this cycle |
| mem_valid | output | 1 | Burst beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW (30) | Burst start word address |
| mem_len | output | 3 | Words in the burst |
| mem_data | output | 32 | Beat data |
| mem_be | output | 4 | Beat write mask (byte enables) |
| mem_last | output | 1 | Final beat of the burst |

## Verification
On every cycle the assertions check that a stalled beat holds its address, data, mask and length. They also check that `mem_last` falls on the beat a separate counter predicts from `mem_len`, that the burst length stays in range, and that the number of held words never exceeds two buffers. Acknowledges and grants are checked to occur only with their requests. Whether words were gathered into the right bursts, whether a sequence break splits them, whether bursts leave in closing order, and whether a hitting read is held until its data has left can only be shown by the bench's scenarios, which compare the logged beats with expected values.

// File: rtl/wpb_pkg.sv
// Shared types for the dual write posting buffer.
package wpb_pkg;
    // Life cycle of one posting buffer.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_FILL  = 2'd1,
        SLOT_FULL  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/wpb_slot.sv
// One posting buffer: start address, word count, word and byte-enable storage.
// Assumes the controller only opens an empty slot, appends to or closes a
// filling slot, and releases a full slot; at most one command per cycle.
module wpb_slot
    import wpb_pkg::*;
#(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = DW / 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_i,
    input  logic            append_i,
    input  logic            close_i,
    input  logic            release_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   data_i,
    input  logic [BEW-1:0]  be_i,
    input  logic [IDXW-1:0] beat_i,
    output slot_state_e     state_o,
    output logic [AW-1:0]   base_o,
    output logic [CNTW-1:0] cnt_o,
    output logic [DW-1:0]   data_o,
    output logic [BEW-1:0]  be_o
);
    logic [DW-1:0]  words [DEPTH];
    logic [BEW-1:0] masks [DEPTH];

    // Slot state and count update on controller commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= SLOT_EMPTY;
            cnt_o   <= '0;
        end else if (open_i) begin
            state_o <= SLOT_FILL;
            cnt_o   <= CNTW'(1);
        end else if (append_i) begin
            cnt_o <= cnt_o + CNTW'(1);
            if (cnt_o == CNTW'(DEPTH - 1)) state_o <= SLOT_FULL;
        end else if (close_i) begin
            state_o <= SLOT_FULL;
        end else if (release_i) begin
            state_o <= SLOT_EMPTY;
            cnt_o   <= '0;
        end
    end

    // Start address capture on open.
    always_ff @(posedge clk) begin
        if (!rst_n) base_o <= '0;
        else if (open_i) base_o <= addr_i;
    end

    // Word and mask storage, written at index 0 on open or at the count on append.
    always_ff @(posedge clk) begin
        if (open_i) begin
            words[0] <= data_i;
            masks[0] <= be_i;
        end else if (append_i) begin
            words[IDXW'(cnt_o)] <= data_i;
            masks[IDXW'(cnt_o)] <= be_i;
        end
    end

    // Beat selection for the drain side.
    always_comb begin
        data_o = words[beat_i];
        be_o   = masks[beat_i];
    end
endmodule

// File: rtl/wpb_hit.sv
// Address match of one word address against the words held in a slot.
// Assumes count never exceeds the slot depth; wraps modulo the address space.
module wpb_hit
    import wpb_pkg::*;
#(
    parameter int AW    = 30,
    parameter int DEPTH = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  slot_state_e     state_i,
    input  logic [AW-1:0]   base_i,
    input  logic [CNTW-1:0] cnt_i,
    input  logic [AW-1:0]   addr_i,
    output logic            hit_o
);
    logic [AW-1:0] offset;

    // Held-word range test.
    always_comb begin
        offset = addr_i - base_i;
        hit_o  = (state_i != SLOT_EMPTY) && (offset < AW'(cnt_i));
    end
endmodule

// File: rtl/wpb_top.sv
// Dual write posting buffer: gathers sequential processor writes into one of
// two slots, drains closed slots in closing order as bursts, and holds off
// reads that hit held words. Assumes the processor raises at most one of
// cpu_rd_req and cpu_wr_req at a time; a read takes precedence if both are set.
module wpb_top
    import wpb_pkg::*;
#(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = DW / 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int NSLOT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_wr_req,
    input  logic [AW-1:0]   cpu_wr_addr,
    input  logic [DW-1:0]   cpu_wr_data,
    input  logic [BEW-1:0]  cpu_wr_be,
    output logic            cpu_wr_ack,
    input  logic            cpu_rd_req,
    input  logic [AW-1:0]   cpu_rd_addr,
    output logic            cpu_rd_grant,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic [CNTW-1:0] mem_len,
    output logic [DW-1:0]   mem_data,
    output logic [BEW-1:0]  mem_be,
    output logic            mem_last
);
    slot_state_e     st    [NSLOT];
    logic [AW-1:0]   base  [NSLOT];
    logic [CNTW-1:0] cnt   [NSLOT];
    logic [DW-1:0]   dout  [NSLOT];
    logic [BEW-1:0]  beout [NSLOT];
    logic [NSLOT-1:0] open_v, app_v, close_v, rel_v, hit;

    logic            wp, wp_n, dp;
    logic [IDXW-1:0] beat;
    logic            seq, fire;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        wpb_slot #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .open_i(open_v[s]), .append_i(app_v[s]),
            .close_i(close_v[s]), .release_i(rel_v[s]),
            .addr_i(cpu_wr_addr), .data_i(cpu_wr_data), .be_i(cpu_wr_be),
            .beat_i(beat),
            .state_o(st[s]), .base_o(base[s]), .cnt_o(cnt[s]),
            .data_o(dout[s]), .be_o(beout[s])
        );
        wpb_hit #(.AW(AW), .DEPTH(DEPTH)) u_hit (
            .state_i(st[s]), .base_i(base[s]), .cnt_i(cnt[s]),
            .addr_i(cpu_rd_addr), .hit_o(hit[s])
        );
    end

    // Write acceptance, sequence detection and read-hit closing.
    always_comb begin
        open_v     = '0;
        app_v      = '0;
        close_v    = '0;
        cpu_wr_ack = 1'b0;
        wp_n       = wp;
        seq        = (cpu_wr_addr == base[wp] + AW'(cnt[wp]));
        if (cpu_rd_req) begin
            if (hit[wp] && st[wp] == SLOT_FILL) begin
                close_v[wp] = 1'b1;
                wp_n        = ~wp;
            end
        end else if (cpu_wr_req) begin
            case (st[wp])
                SLOT_EMPTY: begin
                    open_v[wp] = 1'b1;
                    cpu_wr_ack = 1'b1;
                end
                SLOT_FILL: begin
                    if (seq) begin
                        app_v[wp]  = 1'b1;
                        cpu_wr_ack = 1'b1;
                        if (cnt[wp] == CNTW'(DEPTH - 1)) wp_n = ~wp;
                    end else begin
                        close_v[wp] = 1'b1;
                        wp_n        = ~wp;
                        if (st[~wp] == SLOT_EMPTY) begin
                            open_v[~wp] = 1'b1;
                            cpu_wr_ack  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Read hazard: grant only when no held word matches.
    assign cpu_rd_grant = cpu_rd_req && (hit == '0);

    // Drain side: present the oldest closed slot beat by beat.
    always_comb begin
        mem_valid = (st[dp] == SLOT_FULL);
        mem_addr  = base[dp];
        mem_len   = cnt[dp];
        mem_data  = dout[dp];
        mem_be    = beout[dp];
        mem_last  = (CNTW'(beat) == cnt[dp] - CNTW'(1));
        fire      = mem_valid && mem_ready;
        rel_v     = '0;
        rel_v[dp] = fire && mem_last;
    end

    // Fill pointer, drain pointer and beat index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= 1'b0;
            dp   <= 1'b0;
            beat <= '0;
        end else begin
            wp <= wp_n;
            if (fire) begin
                if (mem_last) begin
                    dp   <= ~dp;
                    beat <= '0;
                end else begin
                    beat <= beat + IDXW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wpb_chk.sv
// Property checker for wpb_top, attached by bind. Tracks beats within a burst
// and words held, independently of the design's own counters.
module wpb_chk #(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = DW / 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_wr_req,
    input logic            cpu_rd_req,
    input logic            cpu_wr_ack,
    input logic            cpu_rd_grant,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic [AW-1:0]   mem_addr,
    input logic [CNTW-1:0] mem_len,
    input logic [DW-1:0]   mem_data,
    input logic [BEW-1:0]  mem_be,
    input logic            mem_last
);
    logic [CNTW-1:0] beat_seen;
    logic [CNTW+1:0] held;

    // Beat-within-burst and held-word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_seen <= '0;
            held      <= '0;
        end else begin
            if (mem_valid && mem_ready)
                beat_seen <= mem_last ? '0 : beat_seen + CNTW'(1);
            held <= held + (CNTW+2)'(cpu_wr_ack) - (CNTW+2)'(mem_valid && mem_ready);
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !mem_valid);

    p_ack_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_ack |-> (cpu_wr_req && !cpu_rd_req));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        held <= (CNTW+2)'(2 * DEPTH));

    p_grant_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_grant |-> cpu_rd_req);

    p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len >= CNTW'(1) && mem_len <= CNTW'(DEPTH)));

    p_last_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_last == (beat_seen == mem_len - CNTW'(1))));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)
            && $stable(mem_data) && $stable(mem_be) && $stable(mem_last)));
endmodule

bind wpb_top wpb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_wpb_top.sv
// Directed bench for wpb_top: one task per scenario, each checking its results.
module tb_wpb_top;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_req = 1'b0;
    logic [AW-1:0] cpu_wr_addr = '0;
    logic [31:0]   cpu_wr_data = '0;
    logic [3:0]    cpu_wr_be = '0;
    logic          cpu_wr_ack;
    logic          cpu_rd_req = 1'b0;
    logic [AW-1:0] cpu_rd_addr = '0;
    logic          cpu_rd_grant;
    logic          mem_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [2:0]    mem_len;
    logic [31:0]   mem_data;
    logic [3:0]    mem_be;
    logic          mem_last;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] lg_addr [64];
    logic [2:0]    lg_len  [64];
    logic [31:0]   lg_data [64];
    logic [3:0]    lg_be   [64];
    logic          lg_last [64];
    int nlog = 0;

    always #4 clk = ~clk;

    wpb_top dut (.*);

    // Beat logger, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && nlog < 64) begin
            lg_addr[nlog] = mem_addr;
            lg_len[nlog]  = mem_len;
            lg_data[nlog] = mem_data;
            lg_be[nlog]   = mem_be;
            lg_last[nlog] = mem_last;
            nlog++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] b, output int waits);
        waits = 0;
        @(negedge clk);
        cpu_wr_req = 1'b1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = b;
        #1;
        while (!cpu_wr_ack && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        @(posedge clk); #1;
        cpu_wr_req = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output int waits);
        waits = 0;
        @(negedge clk);
        cpu_rd_req = 1'b1; cpu_rd_addr = a;
        #1;
        while (!cpu_rd_grant && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        @(posedge clk); #1;
        cpu_rd_req = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        int n = 0;
        while (quiet < 4 && n < 500) begin
            @(negedge clk);
            quiet = mem_valid ? 0 : quiet + 1;
            n++;
        end
    endtask

    task automatic chk_beat(input int i, input logic [AW-1:0] base, input int len,
                            input logic [31:0] d, input logic [3:0] b,
                            input bit last, input string tag);
        chk({tag, " addr"}, lg_addr[i], base);
        chk({tag, " len"},  lg_len[i], len);
        chk({tag, " data"}, lg_data[i], d);
        chk({tag, " be"},   lg_be[i], b);
        chk({tag, " last"}, lg_last[i], last);
    endtask

    // R1: empty after reset, reads granted at once.
    task automatic t_reset();
        int w;
        @(negedge clk);
        chk("R1 mem_valid after reset", mem_valid, 0);
        chk("R1 ack without request", cpu_wr_ack, 0);
        rd(30'h7000, w);
        chk("R1 read miss wait", w, 0);
    endtask

    // R2, R3, R9: four sequential words become one four-beat burst.
    task automatic t_sequential();
        int w, s;
        s = nlog;
        for (int k = 0; k < 4; k++) begin
            wr(30'h100 + k, 32'hA000_0100 + k, 4'hF, w);
            chk("R5 sequential write wait", w, 0);
        end
        wait_quiet();
        chk("R3 beats after full buffer", nlog - s, 4);
        for (int k = 0; k < 4; k++)
            chk_beat(s + k, 30'h100, 4, 32'hA000_0100 + k, 4'hF, k == 3, "R2 seq beat");
    endtask

    // R4, R7: a sequence break splits the bursts; a hitting read waits and flushes.
    task automatic t_break();
        int w, s;
        s = nlog;
        wr(30'h200, 32'hB000_0200, 4'hF, w);
        wr(30'h201, 32'hB000_0201, 4'hF, w);
        wr(30'h300, 32'hB000_0300, 4'hF, w);
        chk("R4 break write wait", w, 0);
        wait_quiet();
        chk("R4 beats after break", nlog - s, 2);
        chk_beat(s,     30'h200, 2, 32'hB000_0200, 4'hF, 0, "R4 beat0");
        chk_beat(s + 1, 30'h200, 2, 32'hB000_0201, 4'hF, 1, "R4 beat1");
        rd(30'h7001, w);
        chk("R7 read miss while held", w, 0);
        rd(30'h300, w);
        chk("R7 read hit stalled", w > 0, 1);
        chk("R7 flushed before grant", nlog - s, 3);
        chk_beat(s + 2, 30'h300, 1, 32'hB000_0300, 4'hF, 1, "R7 flushed beat");
    endtask

    // R8: byte enables reach memory with each beat.
    task automatic t_mask();
        int w, s;
        s = nlog;
        wr(30'h600, 32'hC000_0600, 4'b0001, w);
        wr(30'h601, 32'hC000_0601, 4'b1010, w);
        rd(30'h601, w);
        chk("R8 beat count", nlog - s, 2);
        chk_beat(s,     30'h600, 2, 32'hC000_0600, 4'b0001, 0, "R8 mask beat0");
        chk_beat(s + 1, 30'h600, 2, 32'hC000_0601, 4'b1010, 1, "R8 mask beat1");
    endtask

    // R5, R6, R9, R10: both buffers full under memory stall, then release.
    task automatic t_backpressure();
        int w, s, w9;
        s = nlog;
        @(posedge clk); #1 mem_ready = 1'b0;
        for (int k = 0; k < 8; k++) begin
            wr(30'h400 + k, 32'hD000_0400 + k, 4'hF, w);
            chk("R5 posted under stall", w, 0);
        end
        fork
            wr(30'h500, 32'hD000_0500, 4'h3, w9);
            begin
                @(negedge clk);
                chk("R10 valid under stall", mem_valid, 1);
                chk("R10 addr under stall", mem_addr, 30'h400);
                chk("R10 data under stall", mem_data, 32'hD000_0400);
                repeat (5) @(negedge clk);
                chk("R10 valid still held", mem_valid, 1);
                chk("R10 data still held", mem_data, 32'hD000_0400);
                chk("R6 no ack while full", cpu_wr_ack, 0);
                @(posedge clk); #1 mem_ready = 1'b1;
            end
        join
        chk("R6 stalled write waited", w9 >= 6, 1);
        wait_quiet();
        chk("R9 beats of both buffers", nlog - s, 8);
        for (int k = 0; k < 8; k++)
            chk_beat(s + k, k < 4 ? 30'h400 : 30'h404, 4, 32'hD000_0400 + k, 4'hF,
                     (k % 4) == 3, "R9 order beat");
        rd(30'h500, w);
        chk("R6 stalled word kept", nlog - s, 9);
        chk_beat(s + 8, 30'h500, 1, 32'hD000_0500, 4'h3, 1, "R6 late beat");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sequential();
        t_break();
        t_mask();
        t_backpressure();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule